// File: doc/BRIEF.md
# Programmable chip-select decoder

This block turns a 32-bit bus address into one of several active-low chip-select lines and times each access with a programmable wait-state count. When that count has run out, it returns a one-clock ready pulse. The bus master marks each new access with a single-cycle start pulse and holds the address steady until ready. The decoder latches the winning select, its wait count and its data-width flag at that start edge, so the whole access runs from that snapshot.

Out of reset only select 0 is a chip-select. It acts as a catch-all: every address except three reserved windows selects it, with six wait states, so a boot device can be read before any software runs. Its width flag is taken from a strap input on the first clock after reset. The other selects start in general-purpose I/O mode. Software moves a select between chip-select mode and I/O mode, and gives it a base, a power-of-two size and a wait count, through a single-word configuration write port. Any write to select 0 ends its catch-all behaviour.

Top module: `chip_select_decoder`

## Requirements
- R1: After reset every `cs_n` bit is high, `bus_ready` is low and `pin_is_cs` is 0x01 (only select 0 in chip-select mode).
- R2: Out of reset, an access to any address outside the reserved windows asserts `cs_n[0]` low, with a wait count of 6.
- R3: No select asserts and no ready is given for an address whose upper 16 bits are 0xFFFC or higher, or equal 0xFFF0 (register space) or 0xFFF1 (emulator space). This holds in every mode and for every select. 0xFFFBFFFC still decodes normally.
- R4: Until select 0 is rewritten, `bus_wide` during its accesses equals the level `width_strap` had on the first clock after reset.
- R5: A configuration write to select 0 turns off its catch-all decode. From then on it decodes only its programmed base and size, and uses the written wait count and width.
- R6: Configuration word layout: bits [26:11] are the base (address bits 31:16), [10:6] the size code, [5:2] the wait count, [1] the width flag, and [0] the mode (1 = chip-select, 0 = I/O). A select in I/O mode never asserts its `cs_n` bit, and `pin_is_cs` reflects the mode bits.
- R7: When several enabled selects match, only the lowest-numbered one asserts. At most one `cs_n` bit is ever low.
- R8: `bus_ready` is a one-clock pulse that rises N+1 clocks after the select goes low, where N is the latched wait count. The select is released on the clock after ready.
- R9: All `cs_n` bits are high while no access is in progress.
- R10: A configuration write made during an access does not change that access's select, timing or width. It applies from the next access on.
- R11: A start pulse that arrives while an access is in progress is ignored.
- R12: A size code of k covers 64 KiB << k bytes, aligned on the base. A code of 16 or more covers the whole address space.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| width_strap | input | 1 | Strap level that gives select 0 its reset data width |
| bus_start | input | 1 | One-cycle pulse that begins an access |
| bus_addr | input | 32 | Access address, held until ready |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Index of the select being written |
| cfg_wdata | input | 27 | Configuration word (layout in R6) |
| cs_n | output | 8 | Active-low chip-selects |
| bus_ready | output | 1 | One-cycle access acknowledge |
| bus_wide | output | 1 | Width flag of the running access |
| pin_is_cs | output | 8 | 1 where the pin is a chip-select, 0 where it is I/O |

## Verification
The start pulse is sampled at one rising edge, and the select and width are visible right after that edge. Ready follows exactly N+1 edges later, and the select is high again one edge after ready. The bench drives every input and samples every output at falling edges. After the start pulse it counts falling edges until it sees ready and compares that count with N+1. It then checks release on the next falling edge. For an access that must not decode, it watches for several cycles and expects no select and no ready. Mid-access writes and start pulses are applied on the first falling edge after the select asserts, so their effect, or lack of one, falls inside the access being timed.

// File: rtl/csd_pkg.sv
package csd_pkg;
  localparam int HI_W  = 16;
  localparam int SZ_W  = 5;
  localparam int WS_W  = 4;
  localparam int CFG_W = HI_W + SZ_W + WS_W + 2;

  typedef struct packed {
    logic [HI_W-1:0] base;
    logic [SZ_W-1:0] size;
    logic [WS_W-1:0] ws;
    logic            wide;
    logic            cs_mode;
    logic            catch_all;
  } sel_cfg_t;
endpackage

// File: rtl/csd_match.sv
module csd_match
  import csd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  sel_cfg_t          cfg,
  output logic              hit
);
  localparam int LO_W = ADDR_W - HI_W;

  logic [HI_W-1:0]   mask_hi;
  logic [ADDR_W-1:0] mask_full;
  logic              in_region;

  always_comb begin
    mask_hi   = {HI_W{1'b1}} << cfg.size;
    mask_full = {mask_hi, {LO_W{1'b0}}};
    in_region = ((addr ^ {cfg.base, {LO_W{1'b0}}}) & mask_full) == '0;
    hit       = cfg.cs_mode & (cfg.catch_all | in_region);
  end
endmodule

// File: rtl/csd_prio.sv
module csd_prio #(
  parameter int N_SEL = 8,
  localparam int IDX_W = $clog2(N_SEL)
) (
  input  logic [N_SEL-1:0] req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N_SEL - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/csd_cycle.sv
module csd_cycle #(
  parameter int N_SEL = 8,
  parameter int WS_W  = 4,
  localparam int IDX_W = $clog2(N_SEL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             hit_any,
  input  logic [IDX_W-1:0] hit_idx,
  input  logic [WS_W-1:0]  hit_ws,
  input  logic             hit_wide,
  output logic [N_SEL-1:0] cs_n,
  output logic             ready,
  output logic             wide,
  output logic             busy
);
  logic             busy_q, busy_d;
  logic             ready_q, ready_d;
  logic             wide_q, wide_d;
  logic [WS_W-1:0]  cnt_q, cnt_d;
  logic [N_SEL-1:0] cs_n_q, cs_n_d;
  logic             en;

  always_comb begin
    busy_d  = busy_q;
    ready_d = ready_q;
    wide_d  = wide_q;
    cnt_d   = cnt_q;
    cs_n_d  = cs_n_q;
    en      = start | busy_q;
    if (!busy_q) begin
      if (start && hit_any) begin
        busy_d = 1'b1;
        cnt_d  = hit_ws;
        cs_n_d = ~(N_SEL'(1) << hit_idx);
        wide_d = hit_wide;
      end
    end else if (ready_q) begin
      busy_d  = 1'b0;
      ready_d = 1'b0;
      cs_n_d  = '1;
    end else if (cnt_q == '0) begin
      ready_d = 1'b1;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      ready_q <= 1'b0;
      wide_q  <= 1'b0;
      cnt_q   <= '0;
      cs_n_q  <= '1;
    end else if (en) begin
      busy_q  <= busy_d;
      ready_q <= ready_d;
      wide_q  <= wide_d;
      cnt_q   <= cnt_d;
      cs_n_q  <= cs_n_d;
    end
  end

  assign cs_n  = cs_n_q;
  assign ready = ready_q;
  assign wide  = wide_q;
  assign busy  = busy_q;

  p_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n_q));
  p_ready_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |=> !ready_q);
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |=> (&cs_n_q));
  p_ready_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |-> !(&cs_n_q));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&cs_n_q) && !ready_q) |=> ($stable(cs_n_q) && $stable(wide_q)));
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (&cs_n_q));
endmodule

// File: rtl/chip_select_decoder.sv
module chip_select_decoder
  import csd_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          N_SEL      = 8,
  parameter int          A0_WS      = 6,
  parameter logic [15:0] RSV_TOP_HI = 16'hFFFC,
  parameter logic [15:0] REGS_HI    = 16'hFFF0,
  parameter logic [15:0] EMU_HI     = 16'hFFF1,
  localparam int         IDX_W      = $clog2(N_SEL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              width_strap,
  input  logic              bus_start,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [N_SEL-1:0]  cs_n,
  output logic              bus_ready,
  output logic              bus_wide,
  output logic [N_SEL-1:0]  pin_is_cs
);
  localparam sel_cfg_t CFG_A0 = '{base: '0, size: '0, ws: WS_W'(A0_WS),
                                  wide: 1'b0, cs_mode: 1'b1, catch_all: 1'b1};

  logic [1:0]       rst_sync_q;
  logic             rst_int;
  logic             strap_pend_q;
  logic [HI_W-1:0]  addr_hi;
  logic             excl;
  logic [N_SEL-1:0] raw_hit, hit_vec;
  logic [WS_W-1:0]  ws_vec [N_SEL];
  logic             wide_vec [N_SEL];
  logic             hit_any;
  logic [IDX_W-1:0] hit_idx;
  logic             busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int)          strap_pend_q <= 1'b1;
    else if (strap_pend_q) strap_pend_q <= 1'b0;
  end

  assign addr_hi = bus_addr[ADDR_W-1 -: HI_W];
  assign excl = (addr_hi >= RSV_TOP_HI) | (addr_hi == REGS_HI) | (addr_hi == EMU_HI);

  for (genvar i = 0; i < N_SEL; i++) begin : g_sel
    sel_cfg_t cfg_q, cfg_d;
    logic     cfg_en;

    always_comb begin
      cfg_d  = cfg_q;
      cfg_en = cfg_we | ((i == 0) & strap_pend_q);
      if (i == 0 && strap_pend_q) cfg_d.wide = width_strap;
      if (cfg_we && cfg_sel == IDX_W'(i)) begin
        cfg_d.base      = cfg_wdata[CFG_W-1 -: HI_W];
        cfg_d.size      = cfg_wdata[WS_W+2 +: SZ_W];
        cfg_d.ws        = cfg_wdata[2 +: WS_W];
        cfg_d.wide      = cfg_wdata[1];
        cfg_d.cs_mode   = cfg_wdata[0];
        cfg_d.catch_all = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_int) begin
      if (!rst_int)    cfg_q <= (i == 0) ? CFG_A0 : '0;
      else if (cfg_en) cfg_q <= cfg_d;
    end

    csd_match #(.ADDR_W(ADDR_W)) u_match (
      .addr (bus_addr),
      .cfg  (cfg_q),
      .hit  (raw_hit[i])
    );

    assign ws_vec[i]    = cfg_q.ws;
    assign wide_vec[i]  = cfg_q.wide;
    assign pin_is_cs[i] = cfg_q.cs_mode;

    p_gpio_r6: assert property (@(posedge clk) disable iff (!rst_int)
      (bus_start && !busy && !cfg_q.cs_mode) |=> cs_n[i]);
  end

  assign hit_vec = raw_hit & {N_SEL{~excl}};

  csd_prio #(.N_SEL(N_SEL)) u_prio (
    .req (hit_vec),
    .any (hit_any),
    .idx (hit_idx)
  );

  csd_cycle #(.N_SEL(N_SEL), .WS_W(WS_W)) u_cycle (
    .clk      (clk),
    .rst_n    (rst_int),
    .start    (bus_start),
    .hit_any  (hit_any),
    .hit_idx  (hit_idx),
    .hit_ws   (ws_vec[hit_idx]),
    .hit_wide (wide_vec[hit_idx]),
    .cs_n     (cs_n),
    .ready    (bus_ready),
    .wide     (bus_wide),
    .busy     (busy)
  );

  p_excl_r3: assert property (@(posedge clk) disable iff (!rst_int)
    (bus_start && excl && !busy) |=> (&cs_n));
endmodule

// File: tb/sim_chip_select_decoder.sv
module sim_chip_select_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, width_strap, bus_start, cfg_we;
  logic [31:0] bus_addr;
  logic [2:0]  cfg_sel;
  logic [26:0] cfg_wdata;
  logic [7:0]  cs_n, pin_is_cs;
  logic        bus_ready, bus_wide;
  int          n_checks = 0;
  int          n_fails  = 0;
  bit          done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chip_select_decoder u0 (
    .clk(clk), .rst_n(rst_n), .width_strap(width_strap),
    .bus_start(bus_start), .bus_addr(bus_addr),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cs_n(cs_n), .bus_ready(bus_ready), .bus_wide(bus_wide),
    .pin_is_cs(pin_is_cs)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [26:0] mk(input logic [15:0] base, input logic [4:0] size,
                                     input logic [3:0] ws, input logic wide,
                                     input logic cs);
    return {base, size, ws, wide, cs};
  endfunction

  task automatic wr_cfg(input logic [2:0] idx, input logic [26:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = idx; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_reset(input logic strap, input string req);
    rst_n = 1'b0; width_strap = strap;
    bus_start = 1'b0; cfg_we = 1'b0; bus_addr = '0; cfg_sel = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(cs_n == 8'hFF, req, "reset cs_n", cs_n, 8'hFF);
    chk(!bus_ready, req, "reset ready", bus_ready, 0);
    chk(pin_is_cs == 8'h01, req, "reset pin_is_cs", pin_is_cs, 8'h01);
  endtask

  // mid: 0 none, 1 config write during access, 2 start pulse during access
  task automatic access(input logic [31:0] a, input int exp_idx, input int exp_ws,
                        input bit exp_wide, input string req, input int mid = 0,
                        input logic [2:0] m_idx = '0, input logic [26:0] m_data = '0,
                        input logic [31:0] m_addr = '0);
    int n;
    bit seen;
    @(negedge clk);
    bus_addr = a; bus_start = 1'b1;
    @(negedge clk);
    bus_start = 1'b0;
    if (exp_idx < 0) begin
      seen = 1'b0;
      for (int k = 0; k < 10; k++) begin
        if (cs_n != 8'hFF || bus_ready) seen = 1'b1;
        @(negedge clk);
      end
      chk(!seen, req, "undecoded access produced select or ready", seen, 0);
      return;
    end
    chk(cs_n == ~(8'h01 << exp_idx), req, "select pattern", cs_n, ~(8'h01 << exp_idx));
    chk(bus_wide == exp_wide, req, "width flag", bus_wide, exp_wide);
    if (mid == 1) begin cfg_we = 1'b1; cfg_sel = m_idx; cfg_wdata = m_data; end
    if (mid == 2) begin bus_addr = m_addr; bus_start = 1'b1; end
    n = 0;
    while (!bus_ready && n < 40) begin
      @(negedge clk);
      cfg_we = 1'b0; bus_start = 1'b0;
      if (!bus_ready) bus_addr = a;
      n++;
    end
    chk(n == exp_ws + 1, req, "R8 clocks from select to ready", n, exp_ws + 1);
    chk(cs_n == ~(8'h01 << exp_idx), req, "R8 select held at ready", cs_n, ~(8'h01 << exp_idx));
    @(negedge clk);
    chk(cs_n == 8'hFF && !bus_ready, req, "R9 release after ready", {cs_n, bus_ready}, 9'h1FE);
  endtask

  task automatic t_strap_high;   // R4, R2
    do_reset(1'b1, "R1");
    access(32'h0000_0000, 0, 6, 1'b1, "R4");
  endtask

  task automatic t_default;      // R2, R3 boundary
    do_reset(1'b0, "R1");
    access(32'h8765_4320, 0, 6, 1'b0, "R2");
    access(32'hFFFB_FFFC, 0, 6, 1'b0, "R3");
  endtask

  task automatic t_excl;         // R3
    access(32'hFFFC_0000, -1, 0, 0, "R3");
    access(32'hFFFF_FFFC, -1, 0, 0, "R3");
    access(32'hFFF0_0010, -1, 0, 0, "R3");
    access(32'hFFF1_8000, -1, 0, 0, "R3");
  endtask

  task automatic t_reprogram_a0; // R5
    wr_cfg(3'd0, mk(16'h0000, 5'd4, 4'd1, 1'b1, 1'b1));
    access(32'h000F_FFF0, 0, 1, 1'b1, "R5");
    access(32'h0010_0000, -1, 0, 0, "R5");
    access(32'h2000_0000, -1, 0, 0, "R5");
  endtask

  task automatic t_gpio;         // R6
    wr_cfg(3'd3, mk(16'h3000, 5'd0, 4'd2, 1'b0, 1'b0));
    access(32'h3000_0000, -1, 0, 0, "R6");
    chk(pin_is_cs == 8'h01, "R6", "pin_is_cs with I/O select", pin_is_cs, 8'h01);
    wr_cfg(3'd2, mk(16'h2000, 5'd0, 4'd3, 1'b0, 1'b1));
    chk(pin_is_cs == 8'h05, "R6", "pin_is_cs after enable", pin_is_cs, 8'h05);
    access(32'h2000_0010, 2, 3, 1'b0, "R6");
  endtask

  task automatic t_prio;         // R7
    wr_cfg(3'd1, mk(16'h2000, 5'd1, 4'd0, 1'b0, 1'b1));
    access(32'h2000_0010, 1, 0, 1'b0, "R7");
    access(32'h2001_0000, 1, 0, 1'b0, "R7");
  endtask

  task automatic t_size;         // R12
    wr_cfg(3'd5, mk(16'h4000, 5'd2, 4'd2, 1'b0, 1'b1));
    access(32'h4003_FFF0, 5, 2, 1'b0, "R12");
    access(32'h4004_0000, -1, 0, 0, "R12");
    wr_cfg(3'd7, mk(16'h0000, 5'd16, 4'd5, 1'b1, 1'b1));
    access(32'h7000_0000, 7, 5, 1'b1, "R12");
    access(32'h4000_0000, 5, 2, 1'b0, "R12");
    access(32'hFFFC_0000, -1, 0, 0, "R12");
  endtask

  task automatic t_midwrite;     // R10
    access(32'h7000_0000, 7, 5, 1'b1, "R10", 1, 3'd7, mk(16'h0000, 5'd16, 4'd0, 1'b0, 1'b1));
    access(32'h7000_0000, 7, 0, 1'b0, "R10");
  endtask

  task automatic t_busy_start;   // R11
    bit seen;
    wr_cfg(3'd7, mk(16'h0000, 5'd16, 4'd4, 1'b0, 1'b1));
    access(32'h7000_0000, 7, 4, 1'b0, "R11", 2, 3'd0, '0, 32'h2000_0010);
    seen = 1'b0;
    for (int k = 0; k < 8; k++) begin
      if (cs_n != 8'hFF || bus_ready) seen = 1'b1;
      @(negedge clk);
    end
    chk(!seen, "R11", "start during access began a new access", seen, 0);
  endtask

  initial begin
    t_strap_high();
    t_default();
    t_excl();
    t_reprogram_a0();
    t_gpio();
    t_prio();
    t_size();
    t_midwrite();
    t_busy_start();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL R8 watchdog: act=0 exp=1");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end
endmodule